// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block watches a single asynchronous serial line and turns it into characters. It oversamples the line at sixteen times the bit rate. The tick comes from a programmable 16-bit divisor. The block confirms each start bit at its centre and samples every following bit at its centre. Each character is 7 or 8 data bits, sent least significant bit first. An optional ninth bit can follow the data. That ninth bit is either checked as even or odd parity, or used as an address marker. The character ends with one stop bit.

Finished characters go into a two-entry store. A consumer drains the store through a valid/ready read port. Parity and framing results travel with each character. If the store cannot accept a character, a sticky overrun flag is raised. In address mode the block drops characters until one arrives with the ninth bit set. The input polarity can be inverted for lines that idle low.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rd_valid` and `overrun` are 0.
- R2: With `cfg_ninth`=0 and `cfg_seven`=0, a frame carries a low start bit, 8 data bits LSB first and a high stop bit. It is presented as `rd_data[7:0]` with `rd_data[8]`=0 and both error outputs 0.
- R3: With `cfg_seven`=1, only 7 data bits are received. The stop bit directly follows the seventh bit, and `rd_data[7]` reads 0.
- R4: With `cfg_ninth`=1 (parity), a ninth bit follows the data and is reported in `rd_data[8]`. `cfg_odd`=0 selects even parity and `cfg_odd`=1 selects odd parity, counted over the data bits plus the ninth bit. `rd_parity_err`=1 when that count is wrong.
- R5: A stop bit sampled low is reported as `rd_frame_err`=1 alongside its character.
- R6: The store holds two characters in arrival order. A character that completes while both entries are held and none is being read is dropped, and `overrun` becomes 1.
- R7: `overrun` stays 1 until a one-cycle pulse on `ovr_clear` returns it to 0.
- R8: With `cfg_ninth`=2 (address), a ninth bit follows the data. After reset or an `addr_rearm` pulse, characters with ninth bit 0 are discarded. The first character with ninth bit 1 is stored, and so is every later character until the next `addr_rearm`.
- R9: With `cfg_invert`=1, the line is inverted before use: it idles low, and a start bit is high.
- R10: One bit lasts 16*(`cfg_div`+1) clock cycles.
- R11: A low pulse shorter than half a bit on an idle line is rejected as a false start, and no character results.
- R12: While `rd_ready` is 0, the head character and `rd_valid` stay unchanged. A cycle with `rd_valid` and `rd_ready` both 1 removes the head character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line |
| cfg_div | input | 16 | Divisor; oversample tick every cfg_div+1 cycles |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_ninth | input | 2 | 0 none, 1 parity, 2 address marker |
| cfg_odd | input | 1 | Parity sense, 1 = odd |
| cfg_invert | input | 1 | Invert the serial line |
| addr_rearm | input | 1 | Pulse: wait again for an address character |
| ovr_clear | input | 1 | Pulse: clear the overrun flag |
| rd_valid | output | 1 | Head character available |
| rd_ready | input | 1 | Consumer takes the head character |
| rd_data | output | 9 | Ninth bit and data of the head character |
| rd_parity_err | output | 1 | Parity error of the head character |
| rd_frame_err | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is an overrun. It needs three complete frames to arrive while the consumer stays idle. The flag must then be shown to be sticky, and the two older characters must be shown intact. The bench holds `rd_ready` low across three back-to-back frames. It checks the flag before and after an idle stretch, then drains the store in order and pulses `ovr_clear`. Address filtering also needs a careful order of stimulus: a non-address frame first, then a marker frame, then a plain frame, then a re-arm followed by another plain frame. Only this order shows that characters are dropped, then accepted, then dropped again.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    NINTH_OFF    = 2'd0,
    NINTH_PARITY = 2'd1,
    NINTH_ADDR   = 2'd2
  } ninth_mode_e;

  typedef struct packed {
    logic              frame_err;
    logic              parity_err;
    logic [CHAR_W-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div);
  assign tick = wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rx_bit,
  input  logic     cfg_seven,
  input  logic     ninth_en,
  input  logic     parity_chk,
  input  logic     cfg_odd,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] MID  = SW'(OSR/2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP} st_e;

  st_e         st_q, st_d;
  logic [SW-1:0] sc_q, sc_d;
  logic [2:0]  bc_q, bc_d;
  logic [7:0]  sh_q, sh_d;
  logic        nb_q, nb_d;
  logic        done_q, done_d;
  rx_char_t    char_q, char_d;
  logic        last_bit;
  logic [7:0]  data_fin;

  assign last_bit = cfg_seven ? (bc_q == 3'd6) : (bc_q == 3'd7);
  assign data_fin = cfg_seven ? {1'b0, sh_q[7:1]} : sh_q;

  always_comb begin
    st_d   = st_q;
    sc_d   = sc_q;
    bc_d   = bc_q;
    sh_d   = sh_q;
    nb_d   = nb_q;
    done_d = 1'b0;
    char_d = char_q;
    case (st_q)
      S_IDLE: begin
        if (tick && !rx_bit) begin
          st_d = S_START;
          sc_d = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (sc_q == MID) begin
            sc_d = '0;
            bc_d = '0;
            st_d = rx_bit ? S_IDLE : S_DATA;
          end else begin
            sc_d = sc_q + SW'(1);
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          if (sc_q == LAST) begin
            sc_d = '0;
            sh_d = {rx_bit, sh_q[7:1]};
            bc_d = bc_q + 3'd1;
            if (last_bit) st_d = ninth_en ? S_NINTH : S_STOP;
          end else begin
            sc_d = sc_q + SW'(1);
          end
        end
      end
      S_NINTH: begin
        if (tick) begin
          if (sc_q == LAST) begin
            sc_d = '0;
            nb_d = rx_bit;
            st_d = S_STOP;
          end else begin
            sc_d = sc_q + SW'(1);
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          if (sc_q == LAST) begin
            sc_d              = '0;
            st_d              = S_IDLE;
            done_d            = 1'b1;
            char_d.data       = {ninth_en & nb_q, data_fin};
            char_d.parity_err = parity_chk & ((^data_fin) ^ nb_q ^ cfg_odd);
            char_d.frame_err  = ~rx_bit;
          end else begin
            sc_d = sc_q + SW'(1);
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sc_q   <= '0;
      bc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sc_q   <= sc_d;
      bc_q   <= bc_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    sh_q   <= sh_d;
    nb_q   <= nb_d;
    char_q <= char_d;
  end

  assign done_o = done_q;
  assign char_o = char_q;
endmodule

// File: rtl/rx_store.sv
module rx_store
  import rx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_char_t      push_char,
  input  logic          pop,
  input  logic          ovr_clear,
  output rx_char_t      head,
  output logic          nonempty,
  output logic          full,
  output logic [LW-1:0] level,
  output logic          overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  rx_char_t       mem_q [DEPTH];
  logic [DEPTH-1:0] we;
  logic [PW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0]  lvl_q, lvl_d;
  logic           ovr_q, ovr_d;
  logic           can_write, push_ok, drop;

  assign full      = (lvl_q == LW'(DEPTH));
  assign nonempty  = (lvl_q != '0);
  assign can_write = !full || pop;
  assign push_ok   = push && can_write;
  assign drop      = push && !can_write;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign we[g] = push_ok && (wr_q == PW'(g));
  end

  always_comb begin
    wr_d  = push_ok ? ((wr_q == PLAST) ? '0 : wr_q + PW'(1)) : wr_q;
    rd_d  = pop ? ((rd_q == PLAST) ? '0 : rd_q + PW'(1)) : rd_q;
    lvl_d = lvl_q + LW'(push_ok) - LW'(pop);
    ovr_d = drop ? 1'b1 : (ovr_clear ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) mem_q[i] <= push_char;
    end
  end

  assign head    = mem_q[rd_q];
  assign level   = lvl_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_seven,
  input  logic [1:0]       cfg_ninth,
  input  logic             cfg_odd,
  input  logic             cfg_invert,
  input  logic             addr_rearm,
  input  logic             ovr_clear,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CHAR_W-1:0] rd_data,
  output logic             rd_parity_err,
  output logic             rd_frame_err,
  output logic             overrun
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  ninth_mode_e    mode;
  logic           rx_meta_q, rx_sync_q, rx_bit;
  logic           tick, char_done, accept, pop;
  logic           wait_q, wait_d;
  logic           store_full;
  logic [LVL_W-1:0] fill_lvl;
  rx_char_t       new_char, head_char;

  assign mode = ninth_mode_e'(cfg_ninth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta_q <= 1'b1;
      rx_sync_q <= 1'b1;
    end else begin
      rx_meta_q <= rx_line;
      rx_sync_q <= rx_meta_q;
    end
  end

  assign rx_bit = rx_sync_q ^ cfg_invert;

  rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (cfg_div),
    .tick (tick)
  );

  rx_deframer #(.OSR(OSR)) u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rx_bit    (rx_bit),
    .cfg_seven (cfg_seven),
    .ninth_en  ((mode == NINTH_PARITY) || (mode == NINTH_ADDR)),
    .parity_chk(mode == NINTH_PARITY),
    .cfg_odd   (cfg_odd),
    .done_o    (char_done),
    .char_o    (new_char)
  );

  always_comb begin
    wait_d = wait_q;
    if (addr_rearm) wait_d = 1'b1;
    else if (char_done && (mode == NINTH_ADDR) && new_char.data[CHAR_W-1]) wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b1;
    else        wait_q <= wait_d;
  end

  assign accept = char_done &&
                  !((mode == NINTH_ADDR) && wait_q && !new_char.data[CHAR_W-1]);
  assign pop = rd_valid && rd_ready;

  rx_store #(.DEPTH(DEPTH), .LW(LVL_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_char(new_char),
    .pop      (pop),
    .ovr_clear(ovr_clear),
    .head     (head_char),
    .nonempty (rd_valid),
    .full     (store_full),
    .level    (fill_lvl),
    .overrun  (overrun)
  );

  assign rd_data       = head_char.data;
  assign rd_parity_err = head_char.parity_err;
  assign rd_frame_err  = head_char.frame_err;
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DEPTH = 2,
  parameter int LW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          store_full,
  input logic          pop,
  input logic          overrun,
  input logic          ovr_clear,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [8:0]    rd_data,
  input logic [LW-1:0] fill_lvl
);
  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= LW'(DEPTH));

  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(accept && store_full && !pop));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clear |=> overrun);

  assert_head_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(accept));
endmodule

bind serial_rx_core rx_checker #(.DEPTH(DEPTH), .LW(LVL_W)) u_rx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .store_full(store_full),
  .pop       (pop),
  .overrun   (overrun),
  .ovr_clear (ovr_clear),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .fill_lvl  (fill_lvl)
);

// File: tb/test_serial_rx_core.sv
`timescale 1ns/1ps
module test_serial_rx_core;
  logic        clk;
  logic        rst_n;
  logic        rx_line;
  logic [15:0] cfg_div;
  logic        cfg_seven;
  logic [1:0]  cfg_ninth;
  logic        cfg_odd;
  logic        cfg_invert;
  logic        addr_rearm;
  logic        ovr_clear;
  logic        rd_valid;
  logic        rd_ready;
  logic [8:0]  rd_data;
  logic        rd_parity_err;
  logic        rd_frame_err;
  logic        overrun;

  int checks;
  int failures;
  int bit_clks;
  logic inv_tb;
  bit  finished;

  serial_rx_core i_serial_rx_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_line      (rx_line),
    .cfg_div      (cfg_div),
    .cfg_seven    (cfg_seven),
    .cfg_ninth    (cfg_ninth),
    .cfg_odd      (cfg_odd),
    .cfg_invert   (cfg_invert),
    .addr_rearm   (addr_rearm),
    .ovr_clear    (ovr_clear),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .rd_parity_err(rd_parity_err),
    .rd_frame_err (rd_frame_err),
    .overrun      (overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v ^ inv_tb;
    idle(bit_clks);
  endtask

  task automatic send_char(input logic [8:0] d, input int nbits, input bit with9, input bit stop_ok);
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_bit(d[i]);
    if (with9) drive_bit(d[8]);
    if (stop_ok) begin
      drive_bit(1'b1);
    end else begin
      rx_line = 1'b0 ^ inv_tb;
      idle(bit_clks * 3 / 4);
      rx_line = 1'b1 ^ inv_tb;
      idle(bit_clks - bit_clks * 3 / 4);
    end
    idle(8);
  endtask

  task automatic pop_one();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_char(input string req, input logic [8:0] d, input logic pe, input logic fe);
    check(rd_valid == 1'b1, req, int'(rd_valid), 1);
    check(rd_data == d, req, int'(rd_data), int'(d));
    check(rd_parity_err == pe, req, int'(rd_parity_err), int'(pe));
    check(rd_frame_err == fe, req, int'(rd_frame_err), int'(fe));
    pop_one();
  endtask

  task automatic expect_empty(input string req);
    check(rd_valid == 1'b0, req, int'(rd_valid), 0);
  endtask

  task automatic t_reset_r1();
    check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
  endtask

  task automatic t_basic_r2();
    send_char(9'h0A5, 8, 0, 1);
    expect_char("R2 char A5", 9'h0A5, 1'b0, 1'b0);
    send_char(9'h03C, 8, 0, 1);
    expect_char("R2 char 3C", 9'h03C, 1'b0, 1'b0);
    expect_empty("R2 drained");
  endtask

  task automatic t_seven_r3();
    cfg_seven = 1'b1;
    send_char(9'h0D3, 7, 0, 1);
    expect_char("R3 seven-bit", 9'h053, 1'b0, 1'b0);
    cfg_seven = 1'b0;
  endtask

  task automatic t_parity_r4();
    cfg_ninth = 2'd1;
    cfg_odd   = 1'b0;
    send_char(9'h003, 8, 1, 1);
    expect_char("R4 even ok", 9'h003, 1'b0, 1'b0);
    send_char(9'h103, 8, 1, 1);
    expect_char("R4 even bad", 9'h103, 1'b1, 1'b0);
    cfg_odd = 1'b1;
    send_char(9'h007, 8, 1, 1);
    expect_char("R4 odd ok", 9'h007, 1'b0, 1'b0);
    send_char(9'h107, 8, 1, 1);
    expect_char("R4 odd bad", 9'h107, 1'b1, 1'b0);
    cfg_ninth = 2'd0;
    cfg_odd   = 1'b0;
  endtask

  task automatic t_frame_r5();
    send_char(9'h055, 8, 0, 0);
    expect_char("R5 framing", 9'h055, 1'b0, 1'b1);
    idle(bit_clks * 2);
    expect_empty("R5 no junk char");
  endtask

  task automatic t_overrun_r6_r7();
    send_char(9'h031, 8, 0, 1);
    send_char(9'h032, 8, 0, 1);
    check(overrun == 1'b0, "R6 no overrun at two", int'(overrun), 0);
    send_char(9'h033, 8, 0, 1);
    check(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
    idle(100);
    check(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);
    expect_char("R6 first kept", 9'h031, 1'b0, 1'b0);
    expect_char("R6 second kept", 9'h032, 1'b0, 1'b0);
    expect_empty("R6 third dropped");
    check(overrun == 1'b1, "R7 sticky after reads", int'(overrun), 1);
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
    check(overrun == 1'b0, "R7 cleared", int'(overrun), 0);
  endtask

  task automatic t_addr_r8();
    cfg_ninth = 2'd2;
    addr_rearm = 1'b1;
    @(negedge clk);
    addr_rearm = 1'b0;
    send_char(9'h011, 8, 1, 1);
    expect_empty("R8 non-address discarded");
    send_char(9'h122, 8, 1, 1);
    send_char(9'h033, 8, 1, 1);
    expect_char("R8 address stored", 9'h122, 1'b0, 1'b0);
    expect_char("R8 following stored", 9'h033, 1'b0, 1'b0);
    addr_rearm = 1'b1;
    @(negedge clk);
    addr_rearm = 1'b0;
    send_char(9'h044, 8, 1, 1);
    expect_empty("R8 rearmed discards");
    cfg_ninth = 2'd0;
  endtask

  task automatic t_invert_r9();
    inv_tb     = 1'b1;
    cfg_invert = 1'b1;
    rx_line    = 1'b0;
    idle(bit_clks * 2);
    expect_empty("R9 no false char");
    send_char(9'h096, 8, 0, 1);
    expect_char("R9 inverted", 9'h096, 1'b0, 1'b0);
    inv_tb     = 1'b0;
    cfg_invert = 1'b0;
    rx_line    = 1'b1;
    idle(bit_clks * 2);
  endtask

  task automatic t_div_r10();
    cfg_div  = 16'd3;
    bit_clks = 64;
    idle(bit_clks);
    send_char(9'h0C1, 8, 0, 1);
    expect_char("R10 divisor 3", 9'h0C1, 1'b0, 1'b0);
    cfg_div  = 16'd1;
    bit_clks = 32;
    idle(bit_clks);
  endtask

  task automatic t_glitch_r11();
    rx_line = 1'b0;
    idle(bit_clks / 4);
    rx_line = 1'b1;
    idle(bit_clks * 12);
    expect_empty("R11 glitch rejected");
  endtask

  task automatic t_hold_r12();
    send_char(9'h0E7, 8, 0, 1);
    idle(50);
    check(rd_valid == 1'b1, "R12 held valid", int'(rd_valid), 1);
    check(rd_data == 9'h0E7, "R12 held data", int'(rd_data), 'h0E7);
    pop_one();
    expect_empty("R12 popped");
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    bit_clks = 32; inv_tb = 1'b0;
    rst_n = 1'b0; rx_line = 1'b1; cfg_div = 16'd1; cfg_seven = 1'b0;
    cfg_ninth = 2'd0; cfg_odd = 1'b0; cfg_invert = 1'b0;
    addr_rearm = 1'b0; ovr_clear = 1'b0; rd_ready = 1'b0;
    idle(5);
    t_reset_r1();
    rst_n = 1'b1;
    idle(bit_clks);
    t_basic_r2();
    t_seven_r3();
    t_parity_r4();
    t_frame_r5();
    t_overrun_r6_r7();
    t_addr_r8();
    t_invert_r9();
    t_div_r10();
    t_glitch_r11();
    t_hold_r12();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule